// File: doc/BRIEF.md
# Acquisition Sample FIFO with Interrupt Status

This block collects the results of an analog acquisition front end. Each converted sample arrives with the number of the channel it came from. The block packs the sample and the channel into one 16-bit word and queues the word in a first-in first-out buffer that holds 1024 words by default. A host drains the queue through a data port and watches a status register. The status register has a sticky data-ready flag and a sticky overrun flag.

A control register sets three things: whether the data-ready flag drives the interrupt output, which interrupt line the block reports, and the pacer mode. Clearing the pacer mode also clears the overrun flag. A write strobe to its own address acknowledges the pending interrupt. The same register window also carries four digital input bits and four digital output bits.

Top module: `fifo_status_top`

## Requirements
- R1: On a read of address 0, `rdata_o` carries the queued sample in bits 15:4 and its 4-bit channel number in bits 3:0.
- R2: Samples come out of address 0 in the order they arrived. Each cycle with `rd_i` high at address 0 removes one word when the queue is not empty. Up to DEPTH words are held.
- R3: A read of address 0 on an empty queue returns the last word removed, or 0 after reset. It moves no pointer, so the next sample pushed is the next one read.
- R4: A sample that arrives while the queue is full and no word leaves in that cycle is dropped. The words already held are kept, and status bit 5 (overrun) is set.
- R5: The overrun bit stays set until a write to address 5 with bits 1:0 equal to 0. A write to address 5 with a nonzero value in bits 1:0 leaves it set.
- R6: Status bit 7 (data ready), read at address 2, is set by every sample accepted into the queue. It stays set when the queue is drained. Any write to address 4 clears it, but an accepted sample in the same cycle wins.
- R7: `irq_o` is high exactly when data ready is set and control bit 7 is 1. A dropped sample sets overrun but does not by itself raise `irq_o`.
- R8: The control register at address 5 reads back its last written byte. Its bits 6:4 hold a level code, and `irq_line_o` reports the matching line: codes 0 to 7 give lines 10, 11, 12, 15, 2, 3, 5 and 7.
- R9: `pacer_o` equals bits 1:0 of the control register.
- R10: A read of address 3 returns `din_i` in bits 3:0. A write to address 3 drives `dout_o` from `wdata_i[3:0]`.
- R11: After reset the status, the control register, `dout_o`, `irq_o` and the address 0 read value are all 0, and `irq_line_o` is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | A converted sample is present this cycle |
| smp_data_i | input | 12 | Converted sample value |
| smp_chan_i | input | 4 | Channel the sample came from |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rd_i | input | 1 | Register read strobe (removes a word at address 0) |
| rdata_o | output | 16 | Read data for `addr_i` |
| din_i | input | 4 | Digital input bits |
| dout_o | output | 4 | Digital output bits |
| irq_o | output | 1 | Interrupt request |
| irq_line_o | output | 4 | Interrupt line selected by the level code |
| pacer_o | output | 2 | Pacer mode from the control register |

## Verification
The bench builds the block with DEPTH set to 8. With that depth a handful of pushes fills the queue, so the drop of a sample, the setting of the overrun flag and the check that the held words survive are all within reach of short directed tests. The sample and channel widths keep their default values of 12 and 4, so the packing of the data word is checked at its real layout. All eight level codes are swept.

// File: rtl/fifo_status_pkg.sv
package fifo_status_pkg;
  localparam logic [3:0] ADDR_DATA = 4'd0;
  localparam logic [3:0] ADDR_STAT = 4'd2;
  localparam logic [3:0] ADDR_DIO  = 4'd3;
  localparam logic [3:0] ADDR_ACK  = 4'd4;
  localparam logic [3:0] ADDR_CTRL = 4'd5;

  localparam int STAT_RDY_BIT = 7;
  localparam int STAT_OVR_BIT = 5;
  localparam int CTRL_IE_BIT  = 7;

  typedef struct packed {
    logic       ie;
    logic [2:0] level;
    logic [1:0] spare;
    logic [1:0] pacer;
  } ctrl_t;

  function automatic logic [3:0] level_to_line(input logic [2:0] code);
    logic [3:0] line;
    case (code)
      3'd0: line = 4'd10;
      3'd1: line = 4'd11;
      3'd2: line = 4'd12;
      3'd3: line = 4'd15;
      3'd4: line = 4'd2;
      3'd5: line = 4'd3;
      3'd6: line = 4'd5;
      default: line = 4'd7;
    endcase
    return line;
  endfunction
endpackage

// File: rtl/sample_pack.sv
module sample_pack #(
  parameter int SAMPLE_W = 12,
  parameter int CHAN_W   = 4,
  localparam int WORD_W  = SAMPLE_W + CHAN_W
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [CHAN_W-1:0]   chan_i,
  output logic [WORD_W-1:0]   word_o
);
  // sample left-justified above the channel tag
  always_comb word_o = {sample_i, chan_i};
endmodule

// File: rtl/sample_fifo_mem.sv
module sample_fifo_mem #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             accept_o,
  output logic             drop_o,
  output logic             popped_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;
  logic             do_push, do_pop;

  always_comb begin
    empty_o  = (count_q == '0);
    full_o   = (count_q == CW'(DEPTH));
    do_pop   = pop_i && !empty_o;
    do_push  = push_i && (!full_o || do_pop);
    accept_o = do_push;
    drop_o   = push_i && !do_push;
    popped_o = do_pop;
    head_o   = mem_q[rd_ptr_q];
    count_o  = count_q;
  end

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import fifo_status_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       drop_i,
  input  logic       ack_i,
  input  logic       ctrl_wr_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic       ready_o,
  output logic       ovr_o,
  output ctrl_t      ctrl_o,
  output logic       irq_o
);
  logic  ready_q, ovr_q;
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      ctrl_q  <= '0;
    end else begin
      if (accept_i)   ready_q <= 1'b1;
      else if (ack_i) ready_q <= 1'b0;
      // drop wins over a pacer-off write in the same cycle
      if (drop_i)                                   ovr_q <= 1'b1;
      else if (ctrl_wr_i && ctrl_wdata_i[1:0] == 2'b00) ovr_q <= 1'b0;
      if (ctrl_wr_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
    end
  end

  always_comb begin
    ready_o = ready_q;
    ovr_o   = ovr_q;
    ctrl_o  = ctrl_q;
    irq_o   = ready_q && ctrl_q.ie;
  end
endmodule

// File: rtl/fifo_status_top.sv
module fifo_status_top
  import fifo_status_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int SAMPLE_W = 12,
  parameter int CHAN_W   = 4,
  localparam int WORD_W  = SAMPLE_W + CHAN_W,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  input  logic [CHAN_W-1:0]   smp_chan_i,
  input  logic [3:0]          addr_i,
  input  logic                wr_i,
  input  logic [7:0]          wdata_i,
  input  logic                rd_i,
  output logic [WORD_W-1:0]   rdata_o,
  input  logic [3:0]          din_i,
  output logic [3:0]          dout_o,
  output logic                irq_o,
  output logic [3:0]          irq_line_o,
  output logic [1:0]          pacer_o
);
  logic [WORD_W-1:0] word_in, head, last_q;
  logic              empty, full, accept, drop, popped, ready, ovr;
  logic [CW-1:0]     count;
  logic [3:0]        dout_q;
  ctrl_t             ctrl;
  logic [7:0]        status;

  sample_pack #(.SAMPLE_W(SAMPLE_W), .CHAN_W(CHAN_W)) u_pack (
    .sample_i(smp_data_i), .chan_i(smp_chan_i), .word_o(word_in)
  );

  sample_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(smp_valid_i), .wdata_i(word_in),
    .pop_i(rd_i && addr_i == ADDR_DATA),
    .head_o(head), .empty_o(empty), .full_o(full),
    .accept_o(accept), .drop_o(drop), .popped_o(popped), .count_o(count)
  );

  irq_ctrl u_irq (
    .clk_i, .rst_ni,
    .accept_i(accept), .drop_i(drop),
    .ack_i(wr_i && addr_i == ADDR_ACK),
    .ctrl_wr_i(wr_i && addr_i == ADDR_CTRL),
    .ctrl_wdata_i(wdata_i),
    .ready_o(ready), .ovr_o(ovr), .ctrl_o(ctrl), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      dout_q <= '0;
    end else begin
      if (popped) last_q <= head;
      if (wr_i && addr_i == ADDR_DIO) dout_q <= wdata_i[3:0];
    end
  end

  always_comb begin
    status = '0;
    status[STAT_RDY_BIT] = ready;
    status[STAT_OVR_BIT] = ovr;
    case (addr_i)
      ADDR_DATA: rdata_o = empty ? last_q : head;
      ADDR_STAT: rdata_o = WORD_W'(status);
      ADDR_DIO:  rdata_o = WORD_W'(din_i);
      ADDR_CTRL: rdata_o = WORD_W'(ctrl);
      default:   rdata_o = '0;
    endcase
    dout_o     = dout_q;
    irq_line_o = level_to_line(ctrl.level);
    pacer_o    = ctrl.pacer;
  end
endmodule

// File: rtl/fifo_status_chk.sv
module fifo_status_chk #(
  parameter int DEPTH = 1024,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_valid_i,
  input logic [3:0]    addr_i,
  input logic          wr_i,
  input logic [7:0]    wdata_i,
  input logic          rd_i,
  input logic          irq_o,
  input logic [3:0]    dout_o,
  input logic [CW-1:0] count,
  input logic          ready,
  input logic          ovr,
  input logic          full,
  input logic          empty
);
  // R6
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'd4 && !smp_valid_i) |=> !ready);
  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count) <= DEPTH);
  // R4
  drop_sets_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && full && !(rd_i && addr_i == 4'd0)) |=> ovr);
  // R3
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 4'd0 && empty && !smp_valid_i) |=> (count == '0));
  // R10
  dout_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'd3) |=> (dout_o == $past(wdata_i[3:0])));
  // R7
  irq_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready && !smp_valid_i) |=> !irq_o);
endmodule

bind fifo_status_top fifo_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i),
  .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i),
  .irq_o(irq_o), .dout_o(dout_o), .count(count), .ready(ready),
  .ovr(ovr), .full(full), .empty(empty)
);

// File: tb/fifo_status_top_tb_top.sv
`timescale 1ns/1ps
module fifo_status_top_tb_top;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [11:0] smp_data_i = '0;
  logic [3:0]  smp_chan_i = '0;
  logic [3:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        rd_i = 1'b0;
  logic [15:0] rdata_o;
  logic [3:0]  din_i = '0;
  logic [3:0]  dout_o;
  logic        irq_o;
  logic [3:0]  irq_line_o;
  logic [1:0]  pacer_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  fifo_status_top #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] d, input logic [3:0] c);
    @(negedge clk_i);
    smp_valid_i = 1'b1; smp_data_i = d; smp_chan_i = c;
    @(negedge clk_i);
    smp_valid_i = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk_i);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic pop(output logic [15:0] v);
    @(negedge clk_i);
    addr_i = 4'd0; rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(4'd2, v); check("R11 status", v, 0);
    peek(4'd5, v); check("R11 ctrl", v, 0);
    peek(4'd0, v); check("R11 data", v, 0);
    check("R11 dout", dout_o, 0);
    check("R11 irq", irq_o, 0);
    check("R11 line", irq_line_o, 10);
  endtask

  task automatic t_pack_order();
    logic [15:0] v;
    push(12'hABC, 4'h5);
    peek(4'd2, v); check("R6 ready set", v, 16'h80);
    push(12'h123, 4'hE);
    push(12'hFFF, 4'h0);
    pop(v); check("R1 pack", v, 16'hABC5);
    pop(v); check("R2 order 2", v, 16'h123E);
    pop(v); check("R2 order 3", v, 16'hFFF0);
    peek(4'd2, v); check("R6 sticky after drain", v, 16'h80);
    wr_reg(4'd4, 8'h00);
    peek(4'd2, v); check("R6 ack clears", v, 0);
  endtask

  task automatic t_empty();
    logic [15:0] v;
    pop(v); check("R3 empty returns last", v, 16'hFFF0);
    pop(v); check("R3 empty again", v, 16'hFFF0);
    push(12'h456, 4'h7);
    pop(v); check("R3 no underflow", v, 16'h4567);
    wr_reg(4'd4, 8'h00);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    wr_reg(4'd5, 8'h01);
    for (int i = 0; i < DEPTH; i++) push(12'(i + 16), 4'(i));
    wr_reg(4'd4, 8'h00);
    wr_reg(4'd5, 8'h81);
    check("R7 no irq before drop", irq_o, 0);
    push(12'hDEA, 4'hD);
    peek(4'd2, v); check("R4 overrun status", v, 16'h20);
    check("R7 overrun no irq", irq_o, 0);
    check("R9 pacer", pacer_o, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop(v); check("R4 contents kept", v, {12'(i + 16), 4'(i)});
    end
    peek(4'd2, v); check("R5 ovr sticky", v, 16'h20);
    wr_reg(4'd5, 8'h82);
    peek(4'd2, v); check("R5 nonzero pacer keeps", v, 16'h20);
    check("R9 pacer 2", pacer_o, 2);
    wr_reg(4'd5, 8'h80);
    peek(4'd2, v); check("R5 pacer off clears", v, 0);
    push(12'h001, 4'h1);
    check("R7 irq on ready", irq_o, 1);
    wr_reg(4'd4, 8'h00);
    check("R7 irq cleared", irq_o, 0);
    pop(v);
  endtask

  task automatic t_level();
    logic [15:0] v;
    int exp_line [8] = '{10, 11, 12, 15, 2, 3, 5, 7};
    for (int c = 0; c < 8; c++) begin
      wr_reg(4'd5, {1'b0, 3'(c), 4'h0});
      check("R8 line", irq_line_o, exp_line[c]);
      peek(4'd5, v); check("R8 ctrl readback", v, c << 4);
    end
  endtask

  task automatic t_dio();
    logic [15:0] v;
    din_i = 4'hA;
    peek(4'd3, v); check("R10 din", v, 16'h000A);
    wr_reg(4'd3, 8'hF5);
    check("R10 dout", dout_o, 5);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_pack_order();
    t_empty();
    t_overrun();
    t_level();
    t_dio();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule